// File: doc/BRIEF.md
# Parallel Flash Bus Front End

This block sits between the asynchronous control pins of a 16-bit NOR-style flash device and the clocked command logic behind them. It brings the chip-select, output-gate, write-strobe, address-strobe and power-down/reset pins into the system clock domain and removes short pulses from them. From the cleaned levels it decides which of six bus operations is in progress: read, write, address latch, output disable, standby or reset.

During a write the block records the data word. It also records an address, taken either from the live address pins or from a latch that the address strobe loaded earlier. When the write-strobe or the chip-select rises, whichever comes first, it hands both to the command logic as a single-cycle strobe. During a read it enables the data-bus drivers with the word that the command logic supplies. It reports a low-power state for reset and for standby, and it holds off standby while the command logic is still busy with a program or erase. If power-down is asserted during such an operation, it raises a one-cycle abort pulse.

The address and data pins pass through a delay line that matches the latency of the control pins. The word captured is therefore the one present on the pins just before the closing edge.

Top module: `fbus_front`

## Requirements
- R1: Every control pin passes through two synchronizing flops. A new level is accepted only after GLITCH_CYCLES (default 3) consecutive clock samples agree. A low pulse on the chip-select or write-strobe that lasts fewer samples changes no operation and produces no write strobe. A pulse of exactly GLITCH_CYCLES samples is accepted.
- R2: op_state reports the operation decoded from the filtered pins, using the codes 0 reset, 1 standby, 2 output disable, 3 address latch, 4 read and 5 write. The priority is: power-down low gives reset; otherwise chip-select high gives standby; otherwise output-gate low gives read; otherwise write-strobe low gives write; otherwise address-strobe low gives address latch; otherwise output disable.
- R3: dq_oe is high only in the read operation, and dq_out then equals rd_data. In every other operation dq_oe is low and dq_out is zero.
- R4: A write phase is chip-select low, write-strobe low, output-gate high and power-down high. When it ends because write-strobe or chip-select rises, wr_valid is high for exactly one clock, with wr_data equal to the data pins at the closing edge. Each write gives exactly one strobe.
- R5: If the address strobe is high when the write closes, wr_addr is the latched address. If it is low, wr_addr is the address on the pins at the closing edge.
- R6: The address latch loads the address pins when the address strobe rises while chip-select is low. A rising address strobe with chip-select high leaves the latch unchanged.
- R7: low_power is high in reset, and in standby while busy is low. In standby with busy high, low_power stays low until busy clears.
- R8: When power-down falls while busy is high, abort is high for exactly one clock. A fall while busy is low gives no abort.
- R9: A write phase that is ended by power-down going low produces no write strobe.
- R10: After system reset the filtered pins read as idle with power-down low, so op_state is 0, low_power is 1, and dq_oe, wr_valid and abort are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| ce_n | input | 1 | Chip-select pin, active low |
| oe_n | input | 1 | Output-gate pin, active low |
| we_n | input | 1 | Write-strobe pin, active low |
| le_n | input | 1 | Address-strobe pin, active low |
| rp_n | input | 1 | Power-down/reset pin, active low |
| addr_i | input | ADDR_W | Address pins |
| dq_i | input | DATA_W | Data bus input |
| busy_i | input | 1 | Program or erase in progress, from command logic |
| rd_data_i | input | DATA_W | Read word from command logic |
| dq_out | output | DATA_W | Data bus output value |
| dq_oe | output | 1 | Data bus driver enable |
| op_state | output | 3 | Decoded bus operation code |
| low_power | output | 1 | Standby or reset power state |
| wr_valid | output | 1 | One-cycle strobe for a captured write |
| wr_addr | output | ADDR_W | Captured write address |
| wr_data | output | DATA_W | Captured write data |
| abort | output | 1 | One-cycle abort pulse for a busy operation |

## Verification
The assertions assume that GLITCH_CYCLES is at least two and that busy changes only on clock edges. Each control-pin level must persist for the sample counts that the filter needs. The address and data pins must stay stable from the opening of a write or latch phase until several cycles after its closing edge. The stimulus changes every pin just after a rising clock edge. It holds each level for GLITCH_CYCLES plus five cycles, except in the deliberate short pulses, which are kept below or exactly at the filter length. It changes the address and data only while no strobe phase is open.

// File: rtl/fbus_pkg.sv
`timescale 1ns/1ps
package fbus_pkg;

   localparam int unsigned CTL_PINS = 5;

   typedef enum logic [2:0] {
      OP_RESET   = 3'd0,
      OP_STANDBY = 3'd1,
      OP_OUTDIS  = 3'd2,
      OP_ALATCH  = 3'd3,
      OP_READ    = 3'd4,
      OP_WRITE   = 3'd5
   } bus_op_e;

   typedef struct packed {
      logic ce_n;
      logic oe_n;
      logic we_n;
      logic le_n;
      logic rp_n;
   } bus_ctl_t;

   // idle pins: all strobes released, power-down asserted
   localparam bus_ctl_t CTL_IDLE = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1,
                                     le_n: 1'b1, rp_n: 1'b0};

   function automatic bus_op_e decode_op(input bus_ctl_t c);
      bus_op_e r;
      if (!c.rp_n)      r = OP_RESET;
      else if (c.ce_n)  r = OP_STANDBY;
      else if (!c.oe_n) r = OP_READ;
      else if (!c.we_n) r = OP_WRITE;
      else if (!c.le_n) r = OP_ALATCH;
      else              r = OP_OUTDIS;
      return r;
   endfunction

endpackage

// File: rtl/fbus_pin_filter.sv
`timescale 1ns/1ps
module fbus_pin_filter #(
   parameter int unsigned GLITCH_CYCLES = 3,
   parameter bit          RST_LEVEL     = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic level_o
);
   localparam int unsigned CW = $clog2(GLITCH_CYCLES + 1);

   generate
      if (GLITCH_CYCLES < 2) begin : g_bad_len
         $error("fbus_pin_filter: GLITCH_CYCLES must be 2 or more");
      end
   endgenerate

   logic [1:0]    sync_q;
   logic [CW-1:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q  <= {2{RST_LEVEL}};
         run_q   <= '0;
         level_o <= RST_LEVEL;
      end else begin
         sync_q <= {sync_q[0], pin_i};
         if (sync_q[1] == level_o) begin
            run_q <= '0;
         end else if (run_q == CW'(GLITCH_CYCLES - 1)) begin
            level_o <= sync_q[1];
            run_q   <= '0;
         end else begin
            run_q <= run_q + CW'(1);
         end
      end
   end

   // R1
   level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(level_o) |-> ($past(sync_q[1]) == level_o) && ($past(sync_q[1], 2) == level_o));

endmodule

// File: rtl/fbus_delay_line.sv
`timescale 1ns/1ps
module fbus_delay_line #(
   parameter int unsigned WIDTH  = 16,
   parameter int unsigned STAGES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   // two synchronizing stages followed by the alignment stages
   localparam int unsigned DEPTH = STAGES + 2;

   generate
      if (WIDTH == 0) begin : g_bad_width
         $error("fbus_delay_line: WIDTH must be nonzero");
      end
   endgenerate

   logic [WIDTH-1:0] stg_q [DEPTH];

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_stage
         if (i == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg_q[i] <= '0;
               else        stg_q[i] <= din;
            end
         end else begin : g_body
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg_q[i] <= '0;
               else        stg_q[i] <= stg_q[i-1];
            end
         end
      end
   endgenerate

   assign dout = stg_q[DEPTH-1];

endmodule

// File: rtl/fbus_wr_capture.sv
`timescale 1ns/1ps
module fbus_wr_capture import fbus_pkg::*; #(
   parameter int unsigned ADDR_W = 22,
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  bus_ctl_t          ctl_i,
   input  logic              busy_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              wr_valid_o,
   output logic [ADDR_W-1:0] wr_addr_o,
   output logic [DATA_W-1:0] wr_data_o,
   output logic              abort_o
);
   logic              armed_q;
   logic [ADDR_W-1:0] lat_q;
   logic              le_d_q;
   logic              rp_d_q;
   logic              write_phase;
   logic              write_close;
   logic              le_rise;

   assign write_phase = !ctl_i.ce_n && !ctl_i.we_n && ctl_i.oe_n && ctl_i.rp_n;
   assign write_close = armed_q && !write_phase && ctl_i.rp_n && (ctl_i.ce_n || ctl_i.we_n);
   assign le_rise     = ctl_i.le_n && !le_d_q && !ctl_i.ce_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q    <= 1'b0;
         wr_valid_o <= 1'b0;
         wr_addr_o  <= '0;
         wr_data_o  <= '0;
         lat_q      <= '0;
         le_d_q     <= CTL_IDLE.le_n;
         rp_d_q     <= CTL_IDLE.rp_n;
         abort_o    <= 1'b0;
      end else begin
         armed_q    <= write_phase;
         wr_valid_o <= write_close;
         if (write_close) begin
            wr_addr_o <= ctl_i.le_n ? lat_q : addr_i;
            wr_data_o <= data_i;
         end
         if (le_rise) lat_q <= addr_i;
         le_d_q  <= ctl_i.le_n;
         rp_d_q  <= ctl_i.rp_n;
         abort_o <= !ctl_i.rp_n && rp_d_q && busy_i;
      end
   end

   // R4
   strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid_o |=> !wr_valid_o);

   // R9
   strobe_no_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid_o |-> $past(ctl_i.rp_n));

   // R6
   latch_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(lat_q) |-> !$past(ctl_i.ce_n));

   // R8
   abort_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      abort_o |=> !abort_o);

   // R8
   abort_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      abort_o |-> $past(busy_i));

endmodule

// File: rtl/fbus_front.sv
`timescale 1ns/1ps
module fbus_front import fbus_pkg::*; #(
   parameter int unsigned ADDR_W        = 22,
   parameter int unsigned DATA_W        = 16,
   parameter int unsigned GLITCH_CYCLES = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic              le_n,
   input  logic              rp_n,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] dq_i,
   input  logic              busy_i,
   input  logic [DATA_W-1:0] rd_data_i,
   output logic [DATA_W-1:0] dq_out,
   output logic              dq_oe,
   output logic [2:0]        op_state,
   output logic              low_power,
   output logic              wr_valid,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic              abort
);
   // pins move 2 sync + GLITCH_CYCLES filter + 1 decode cycles; bus words follow
   localparam int unsigned ALIGN_STAGES = GLITCH_CYCLES + 1;
   localparam logic [CTL_PINS-1:0] IDLE_VEC = CTL_IDLE;

   generate
      if (ADDR_W == 0 || DATA_W == 0) begin : g_bad_bus
         $error("fbus_front: ADDR_W and DATA_W must be nonzero");
      end
      if (GLITCH_CYCLES < 2) begin : g_bad_filter
         $error("fbus_front: GLITCH_CYCLES must be 2 or more");
      end
   endgenerate

   bus_ctl_t            raw_ctl;
   bus_ctl_t            flt_ctl;
   logic [CTL_PINS-1:0] raw_vec;
   logic [CTL_PINS-1:0] flt_vec;
   logic [ADDR_W-1:0]   addr_al;
   logic [DATA_W-1:0]   data_al;
   bus_op_e             cur_op;

   assign raw_ctl = '{ce_n: ce_n, oe_n: oe_n, we_n: we_n, le_n: le_n, rp_n: rp_n};
   assign raw_vec = raw_ctl;

   generate
      for (genvar p = 0; p < CTL_PINS; p++) begin : g_pin
         fbus_pin_filter #(
            .GLITCH_CYCLES (GLITCH_CYCLES),
            .RST_LEVEL     (IDLE_VEC[p])
         ) u_filt (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin_i   (raw_vec[p]),
            .level_o (flt_vec[p])
         );
      end
   endgenerate

   assign flt_ctl = bus_ctl_t'(flt_vec);

   fbus_delay_line #(.WIDTH(ADDR_W), .STAGES(ALIGN_STAGES)) u_addr_dly (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (addr_i),
      .dout  (addr_al)
   );

   fbus_delay_line #(.WIDTH(DATA_W), .STAGES(ALIGN_STAGES)) u_data_dly (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (dq_i),
      .dout  (data_al)
   );

   assign cur_op    = decode_op(flt_ctl);
   assign op_state  = cur_op;
   assign dq_oe     = (cur_op == OP_READ);
   assign dq_out    = dq_oe ? rd_data_i : '0;
   assign low_power = (cur_op == OP_RESET) || ((cur_op == OP_STANDBY) && !busy_i);

   fbus_wr_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctl_i      (flt_ctl),
      .busy_i     (busy_i),
      .addr_i     (addr_al),
      .data_i     (data_al),
      .wr_valid_o (wr_valid),
      .wr_addr_o  (wr_addr),
      .wr_data_o  (wr_data),
      .abort_o    (abort)
   );

   // R2
   op_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_state <= 3'd5);

   // R3
   drive_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe |-> !low_power);

   // R7
   stby_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_state == 3'd1 && busy_i) |-> !low_power);

   // R8
   abort_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      abort |-> op_state == 3'd0);

endmodule

// File: tb/test_fbus_front.sv
`timescale 1ns/1ps
module test_fbus_front;
   localparam int AW = 22;
   localparam int DW = 16;
   localparam int G  = 3;
   localparam int H  = G + 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, le_n = 1'b1, rp_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] dq = '0;
   logic busy = 1'b0;
   logic [DW-1:0] rd_data = '0;

   logic [DW-1:0] dq_out;
   logic          dq_oe;
   logic [2:0]    op_state;
   logic          low_power;
   logic          wr_valid;
   logic [AW-1:0] wr_addr;
   logic [DW-1:0] wr_data;
   logic          abort;

   int checks = 0;
   int errors = 0;
   int obs_wr = 0;
   int exp_wr = 0;
   int obs_ab = 0;
   bit saw_write = 0;
   logic [AW-1:0] last_wa = '0;
   logic [DW-1:0] last_wd = '0;

   always #2.5 clk = ~clk;

   fbus_front #(.ADDR_W(AW), .DATA_W(DW), .GLITCH_CYCLES(G)) i_fbus_front (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
      .le_n(le_n), .rp_n(rp_n), .addr_i(addr), .dq_i(dq), .busy_i(busy),
      .rd_data_i(rd_data), .dq_out(dq_out), .dq_oe(dq_oe), .op_state(op_state),
      .low_power(low_power), .wr_valid(wr_valid), .wr_addr(wr_addr),
      .wr_data(wr_data), .abort(abort));

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   // pin vector bits: [4] ce, [3] oe, [2] we, [1] le, [0] rp
   logic [4:0]    hq[$];
   logic [AW-1:0] aq[$];
   logic [DW-1:0] dh[$];
   logic [4:0]    mf, pf;
   bit            m_arm, m_wv, m_ab, m_le_d, m_rp_d;
   logic [AW-1:0] m_wa, m_lat, ad;
   logic [DW-1:0] m_wd, dd;
   int            n;
   logic          vbit;
   bit            same;

   function automatic int op_of(input logic [4:0] v);
      if (!v[0]) return 0;
      if (v[4])  return 1;
      if (!v[3]) return 4;
      if (!v[2]) return 5;
      if (!v[1]) return 3;
      return 2;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         hq.delete(); aq.delete(); dh.delete();
         repeat (G + 4) begin
            hq.push_back(5'b11110); aq.push_back('0); dh.push_back('0);
         end
         mf = 5'b11110; m_arm = 0; m_wv = 0; m_ab = 0;
         m_le_d = 1; m_rp_d = 0; m_wa = '0; m_wd = '0; m_lat = '0;
      end else begin
         pf = mf;
         hq.push_back({ce_n, oe_n, we_n, le_n, rp_n});
         aq.push_back(addr);
         dh.push_back(dq);
         n = hq.size() - 1;
         for (int b = 0; b < 5; b++) begin
            vbit = hq[n-2][b];
            same = 1;
            for (int j = 1; j < G; j++)
               if (hq[n-2-j][b] !== vbit) same = 0;
            if (same) mf[b] = vbit;
         end
         ad = aq[n-G-3];
         dd = dh[n-G-3];
         m_wv = 0;
         if (!pf[4] && !pf[2] && pf[3] && pf[0]) begin
            m_arm = 1;
         end else begin
            if (m_arm && pf[0] && (pf[4] || pf[2])) begin
               m_wv = 1;
               m_wa = pf[1] ? m_lat : ad;
               m_wd = dd;
            end
            m_arm = 0;
         end
         if (pf[1] && !m_le_d && !pf[4]) m_lat = ad;
         m_ab   = !pf[0] && m_rp_d && busy;
         m_le_d = pf[1];
         m_rp_d = pf[0];
         while (hq.size() > G + 10) begin
            void'(hq.pop_front()); void'(aq.pop_front()); void'(dh.pop_front());
         end
      end
   end

   // per-cycle comparison away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         int eop;
         eop = op_of(mf);
         check("R2 op_state", 32'(op_state), 32'(eop));
         check("R3 dq_oe", 32'(dq_oe), 32'(eop == 4));
         check("R3 dq_out", 32'(dq_out), (eop == 4) ? 32'(rd_data) : 32'd0);
         check("R7 low_power", 32'(low_power), 32'((eop == 0) || (eop == 1 && !busy)));
         check("R4 wr_valid", 32'(wr_valid), 32'(m_wv));
         if (m_wv) begin
            check("R5 wr_addr", 32'(wr_addr), 32'(m_wa));
            check("R4 wr_data", 32'(wr_data), 32'(m_wd));
         end
         check("R8 abort", 32'(abort), 32'(m_ab));
         if (wr_valid) begin
            obs_wr++; last_wa = wr_addr; last_wd = wr_data;
         end
         if (abort) obs_ab++;
         if (op_state == 3'd5) saw_write = 1;
      end
   end

   // ---------------- stimulus ----------------
   task automatic step(input int k);
      repeat (k) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic write_live(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit end_by_ce);
      addr = a; ce_n = 0; le_n = 0; step(H);
      we_n = 0; dq = d; step(H);
      if (end_by_ce) begin ce_n = 1; step(H); we_n = 1; end
      else begin we_n = 1; step(H); ce_n = 1; end
      step(H);
      le_n = 1; step(H);
      exp_wr++;
      check("R4 strobe count", 32'(obs_wr), 32'(exp_wr));
      check("R5 live address", 32'(last_wa), 32'(a));
      check("R4 data word", 32'(last_wd), 32'(d));
   endtask

   task automatic latch_addr(input logic [AW-1:0] a);
      addr = a; ce_n = 0; le_n = 0; step(H);
      le_n = 1; step(H);
      ce_n = 1; step(H);
   endtask

   task automatic write_latched(input logic [AW-1:0] junk, input logic [DW-1:0] d);
      addr = junk; ce_n = 0; step(H);
      we_n = 0; dq = d; step(H);
      we_n = 1; step(H);
      ce_n = 1; step(H);
      exp_wr++;
      check("R4 strobe count", 32'(obs_wr), 32'(exp_wr));
      check("R4 data word", 32'(last_wd), 32'(d));
   endtask

   initial begin
      step(4);
      rst_n = 1;
      step(1);
      // R10 reset state
      check("R10 op after reset", 32'(op_state), 32'd0);
      check("R10 low_power after reset", 32'(low_power), 32'd1);
      check("R10 dq_oe after reset", 32'(dq_oe), 32'd0);
      check("R10 wr_valid after reset", 32'(wr_valid), 32'd0);
      check("R10 abort after reset", 32'(abort), 32'd0);
      rp_n = 1; step(H);
      check("R2 standby code", 32'(op_state), 32'd1);

      // writes closed by each strobe
      write_live(22'h012345, 16'hBEEF, 1'b0);
      write_live(22'h3ABCDE, 16'h1234, 1'b1);

      // R5 and R6: latched address
      latch_addr(22'h00A5A5);
      write_latched(22'h3FFFFF, 16'h5A5A);
      check("R5 latched address", 32'(last_wa), 32'h00A5A5);
      le_n = 0; addr = 22'h111111; step(H);
      le_n = 1; step(H);
      write_latched(22'h222222, 16'hC3C3);
      check("R6 latch kept with ce high", 32'(last_wa), 32'h00A5A5);

      // R3 read
      rd_data = 16'h7E81; ce_n = 0; oe_n = 0; step(H);
      check("R3 read drive", 32'(dq_oe), 32'd1);
      check("R3 read data", 32'(dq_out), 32'h7E81);
      check("R2 read code", 32'(op_state), 32'd4);
      oe_n = 1; step(H);
      check("R3 output disable", 32'(dq_oe), 32'd0);
      check("R2 output disable code", 32'(op_state), 32'd2);
      le_n = 0; step(H);
      check("R2 address latch code", 32'(op_state), 32'd3);
      le_n = 1; ce_n = 1; step(H);

      // R1 glitches on we and on ce
      saw_write = 0;
      ce_n = 0; step(H);
      we_n = 0; step(G - 1); we_n = 1; step(H);
      ce_n = 1; step(H);
      we_n = 0; step(H);
      ce_n = 0; step(G - 1); ce_n = 1; step(H);
      we_n = 1; step(H);
      check("R1 no strobe from glitches", 32'(obs_wr), 32'(exp_wr));
      check("R1 no write op from glitches", 32'(saw_write), 32'd0);

      // R1 pulse of exactly GLITCH_CYCLES samples is accepted
      ce_n = 0; le_n = 0; addr = 22'h000777; step(H);
      we_n = 0; dq = 16'h0F0F; step(G); we_n = 1; step(H);
      ce_n = 1; step(H); le_n = 1; step(H);
      exp_wr++;
      check("R1 minimum pulse accepted", 32'(obs_wr), 32'(exp_wr));
      check("R1 minimum pulse data", 32'(last_wd), 32'h0F0F);

      // R7 standby deferred by busy
      ce_n = 0; step(H);
      busy = 1; ce_n = 1; step(H);
      check("R7 standby held off while busy", 32'(low_power), 32'd0);
      check("R2 standby code while busy", 32'(op_state), 32'd1);
      busy = 0; step(1);
      check("R7 standby after busy clears", 32'(low_power), 32'd1);

      // R8 abort only when busy
      busy = 1; rp_n = 0; step(H);
      check("R8 abort count busy", 32'(obs_ab), 32'd1);
      check("R2 reset code", 32'(op_state), 32'd0);
      rp_n = 1; step(H); busy = 0;
      rp_n = 0; step(H);
      check("R8 no abort when idle", 32'(obs_ab), 32'd1);
      rp_n = 1; step(H);

      // R9 write cut by reset
      ce_n = 0; step(H);
      we_n = 0; dq = 16'hDEAD; step(H);
      rp_n = 0; step(H);
      check("R3 no drive in reset", 32'(dq_oe), 32'd0);
      we_n = 1; ce_n = 1; step(H);
      rp_n = 1; step(H);
      check("R9 no strobe after reset cut", 32'(obs_wr), 32'(exp_wr));

      step(4);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule